// File: doc/BRIEF.md
# Scaled-Sum Systolic Chain Stage

This block is one link of a linear chain that builds a weighted sum of several vectors, element by element: S[i] = c1·V1[i] + c2·V2[i] + …. Every stage has its own local memory and two 32-bit neighbour buses, one on the left and one on the right, each with a strobe. After reset the stage reads three setup words from its memory: a role word, a signed 16-bit weight and an element count. The role makes it a source, a summing stage, a sink or an inert stage.

A source stage streams `weight × element` to the right, one word per clock. A summing stage adds its own weighted element to the 32-bit partial sum that arrives from the left in the same cycle. It passes the result to the right one clock later. A sink stage stores the upper 16 bits of each arriving sum in its memory, then raises a one-cycle interrupt when the stream ends. A chain is built as one source, any number of summing stages and one sink. A stage either reads its memory or writes it, but never does both, so the memory port never has to turn around.

Top module: `scaled_sum_stage`

## Requirements
- R1: While reset is held, `right_stb`, `irq` and `mem_wr_en` are low. After reset is released, the stage reads address 0, then 1, then 2, on consecutive cycles. It drives no strobe, no write and no interrupt during its first four cycles.
- R2: Bits [1:0] of word 0 pick the role: 00 inert, 01 source, 10 summing, 11 sink. All other bits of word 0 are ignored.
- R3: A source stage starts on the first cycle after setup in which `left_stb` is high, and ignores `left_data`. Element i sits at address 3+i. One cycle after consuming element i, the stage presents weight × element (signed 16×16, 32-bit result) on `right_data` with `right_stb` high. The products appear on consecutive cycles.
- R4: A summing stage starts the same way. Each output equals the `left_data` of its consume cycle plus weight × element, wrapped modulo 2^32. The stage takes one left word per cycle from the start cycle onward.
- R5: Source and summing stages stop after exactly `count` (word 2) elements. After that, `right_stb` stays low, memory reads cease, and later strobes are ignored until the next reset.
- R6: With a count of 0, a source or summing stage emits nothing.
- R7: A sink stage writes `left_data[31:16]` to address 3+i for the i-th cycle in which `left_stb` is high. It stops at the first cycle in which the strobe is low.
- R8: A sink raises `irq` for exactly one cycle: the cycle after the first low strobe that follows its run. Strobes that arrive afterwards cause no writes.
- R9: A sink never reads data addresses and never drives `right_stb`. Source and summing stages never write memory.
- R10: An inert stage issues no reads after setup, no writes, no strobe and no interrupt.
- R11: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| left_data | input | 32 | Partial sum from the left neighbour |
| left_stb | input | 1 | Left word valid; its first assertion starts a run |
| right_data | output | 32 | Product or sum to the right neighbour |
| right_stb | output | 1 | Right word valid |
| mem_rd_en | output | 1 | Local memory read (data returned one clock later) |
| mem_wr_en | output | 1 | Local memory write |
| mem_addr | output | 10 | Local memory address |
| mem_wdata | output | 16 | Write data (upper half of `left_data`) |
| mem_rdata | input | 16 | Read data from local memory |
| irq | output | 1 | One-cycle end-of-run pulse from a sink |

## Verification
The assertions watch properties that hold on every cycle:
- the read and write enables are exclusive;
- the interrupt lasts one cycle and follows a low strobe;
- the output strobe only rises after an input strobe;
- reads stop once the output stream ends;
- the stage stays quiet during setup.

The values carried by the stream can only be shown by the bench scenarios, which compare each cycle against a behavioural model. These values are the weighted products, the 32-bit wrap of the running sum, the exact count, and the sink's memory contents. The same goes for the effect of role bits and ignored upper bits, the zero-count case, and strobes that arrive after completion.

// File: rtl/ssum_pkg.sv
// Shared types for the scaled-sum chain stage.
// Assumes: role code sits in bits [1:0] of setup word 0.
package ssum_pkg;

    typedef enum logic [1:0] {
        ROLE_IDLE  = 2'b00,
        ROLE_READ  = 2'b01,
        ROLE_ADD   = 2'b10,
        ROLE_WRITE = 2'b11
    } role_e;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_ARMED,
        ST_RUN,
        ST_DONE
    } state_e;

    // first element address; words 0..2 hold role, weight, count
    localparam int unsigned DATA_BASE = 3;

endpackage

// File: rtl/ssum_ctrl.sv
// Control for one chain stage: setup read, role decode, run/stop
// sequencing, memory addressing and the sink's end-of-run pulse.
// Assumes: memory returns read data one clock after the request.
// Source/summing stages prefetch element 0 so a run can start with
// zero wait on the first incoming strobe.
module ssum_ctrl
    import ssum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_stb,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              consume,
    output logic              add_en,
    output logic [DATA_W-1:0] coef,
    output logic              irq
);

    state_e            state;
    role_e             role_q;
    logic [1:0]        init_cnt;
    logic [DATA_W-1:0] coef_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] idx;
    logic              irq_q;

    logic is_src;
    logic active;
    logic last;

    // role and phase decode
    always_comb begin
        is_src  = (role_q == ROLE_READ) || (role_q == ROLE_ADD);
        active  = (state == ST_ARMED) || (state == ST_RUN);
        consume = is_src && (count_q != '0) &&
                  (((state == ST_ARMED) && left_stb) || (state == ST_RUN));
        last    = consume && (idx == count_q - 1'b1);
        add_en  = (role_q == ROLE_ADD);
    end

    // memory port: setup reads, element prefetch, sink writes
    always_comb begin
        mem_wr_en = (role_q == ROLE_WRITE) && active && left_stb;
        if (state == ST_INIT) begin
            mem_rd_en = (init_cnt != 2'd3) || is_src;
            mem_addr  = (init_cnt != 2'd3) ? ADDR_W'(init_cnt)
                                           : ADDR_W'(DATA_BASE);
        end else begin
            mem_rd_en = is_src && active;
            mem_addr  = ADDR_W'(DATA_BASE) + ADDR_W'(idx) + ADDR_W'(consume);
        end
    end

    // sequencing of setup, run and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            role_q   <= ROLE_IDLE;
            init_cnt <= '0;
            coef_q   <= '0;
            count_q  <= '0;
            idx      <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                ST_INIT: begin
                    init_cnt <= init_cnt + 1'b1;
                    if (init_cnt == 2'd1) role_q  <= role_e'(mem_rdata[1:0]);
                    if (init_cnt == 2'd2) coef_q  <= mem_rdata;
                    if (init_cnt == 2'd3) begin
                        count_q <= mem_rdata;
                        state   <= (role_q == ROLE_IDLE) ? ST_DONE : ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (left_stb) begin
                        if (role_q == ROLE_WRITE) begin
                            idx   <= idx + 1'b1;
                            state <= ST_RUN;
                        end else if (!consume || last) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (role_q == ROLE_WRITE) begin
                        if (left_stb) begin
                            idx <= idx + 1'b1;
                        end else begin
                            state <= ST_DONE;
                            irq_q <= 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                        if (last) state <= ST_DONE;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    assign coef = coef_q;
    assign irq  = irq_q;

endmodule

// File: rtl/ssum_datapath.sv
// Weighted multiply-add and the right-bus output register.
// Assumes: element and weight are signed two's complement; the sum
// wraps modulo 2^(2*DATA_W). Output appears one clock after consume.
module ssum_datapath #(
    parameter int DATA_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume,
    input  logic             add_en,
    input  logic [DATA_W-1:0] coef,
    input  logic [DATA_W-1:0] elem,
    input  logic [ACC_W-1:0] left_data,
    output logic [ACC_W-1:0] right_data,
    output logic             right_stb
);

    logic signed [ACC_W-1:0] prod;
    logic        [ACC_W-1:0] sum;

    // single-cycle signed product plus optional left partial sum
    always_comb begin
        prod = $signed(coef) * $signed(elem);
        sum  = (add_en ? left_data : '0) + ACC_W'(prod);
    end

    // register the result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            right_stb  <= 1'b0;
            right_data <= '0;
        end else begin
            right_stb <= consume;
            if (consume) right_data <= sum;
        end
    end

endmodule

// File: rtl/scaled_sum_stage.sv
// One stage of a weighted-sum systolic chain. Role, weight and count
// come from local memory words 0..2 after each reset; elements and
// results live from address 3 upward.
// Assumes: synchronous-read memory with one clock of latency; the
// upstream neighbour delivers a gap-free stream once started.
module scaled_sum_stage #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   left_data,
    input  logic                  left_stb,
    output logic [2*DATA_W-1:0]   right_data,
    output logic                  right_stb,
    output logic                  mem_rd_en,
    output logic                  mem_wr_en,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  irq
);

    localparam int ACC_W = 2 * DATA_W;

    logic              consume;
    logic              add_en;
    logic [DATA_W-1:0] coef;

    ssum_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .left_stb  (left_stb),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .consume   (consume),
        .add_en    (add_en),
        .coef      (coef),
        .irq       (irq)
    );

    ssum_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .consume    (consume),
        .add_en     (add_en),
        .coef       (coef),
        .elem       (mem_rdata),
        .left_data  (left_data),
        .right_data (right_data),
        .right_stb  (right_stb)
    );

    // sink stores the upper half of the arriving sum
    assign mem_wdata = left_data[ACC_W-1:DATA_W];

endmodule

// File: rtl/ssum_stage_chk.sv
// Protocol checker for scaled_sum_stage, attached by bind.
module ssum_stage_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*DATA_W-1:0] left_data,
    input logic                left_stb,
    input logic [2*DATA_W-1:0] right_data,
    input logic                right_stb,
    input logic                mem_rd_en,
    input logic                mem_wr_en,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [DATA_W-1:0]   mem_rdata,
    input logic                irq
);

    logic [2:0] age;

    // cycles since reset, saturating at the end of setup
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (age != 3'd4)  age <= age + 1'b1;
    end

    assert_quiet_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age < 3'd4) |-> (!right_stb && !mem_wr_en && !irq));

    assert_start_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(right_stb) |-> $past(left_stb));

    assert_reads_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(right_stb) |-> !mem_rd_en);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(left_stb));

    assert_sink_silent_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !right_stb);

    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

endmodule

bind scaled_sum_stage ssum_stage_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/scaled_sum_stage_bench.sv
`timescale 1ns/1ps
module scaled_sum_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] left_data = '0;
    logic        left_stb = 1'b0;
    logic [31:0] right_data;
    logic        right_stb;
    logic        mem_rd_en, mem_wr_en;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    scaled_sum_stage u_scaled_sum_stage (.*);

    int n_run = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // local memory model and activity counters
    logic [15:0] mem  [0:1023];
    logic [15:0] wmem [0:1023];
    int wr_seen, rd_data_seen, stb_seen, irq_seen;

    always @(posedge clk) begin
        if (!rst_n) begin
            wr_seen = 0; rd_data_seen = 0; stb_seen = 0; irq_seen = 0;
            for (int i = 0; i < 1024; i++) wmem[i] = '0;
        end else begin
            check(!(mem_rd_en && mem_wr_en), "R11", {mem_rd_en, mem_wr_en}, 0);
            if (mem_wr_en) begin wmem[mem_addr] = mem_wdata; wr_seen++; end
            if (mem_rd_en && mem_addr >= 10'd3) rd_data_seen++;
            if (right_stb) stb_seen++;
            if (irq) irq_seen++;
        end
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    // behavioural reference: expected right bus and irq per cycle
    int          mrole, mcnt, ki;
    int          edges, midx;
    bit          started, done;
    bit          m_stb, m_irq;
    logic [31:0] m_data;

    always @(posedge clk) begin
        m_stb = 0; m_irq = 0;
        if (!rst_n) begin
            edges = 0; midx = 0; started = 0; done = 0;
        end else if (edges < 4) begin
            edges++;
        end else if (mrole == 1 || mrole == 2) begin
            if (!started && !done && left_stb) begin
                started = 1;
                if (mcnt == 0) done = 1;
            end
            if (started && !done) begin
                int ei;
                ei = $signed(mem[3 + midx]);
                m_data = ((mrole == 2) ? left_data : 32'd0) + 32'(ki * ei);
                m_stb = 1;
                midx++;
                if (midx == mcnt) done = 1;
            end
        end else if (mrole == 3) begin
            if (!done && left_stb) started = 1;
            else if (started && !done) begin done = 1; m_irq = 1; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && edges > 0) begin
            check(right_stb == m_stb, cur_tag, right_stb, m_stb);
            if (m_stb) check(right_data == m_data, cur_tag, right_data, m_data);
            check(irq == m_irq, "R8", irq, m_irq);
        end
    end

    logic [31:0] stream [0:7];

    task automatic setup(input logic [15:0] cfg, input logic [15:0] k, input logic [15:0] cnt);
        mem[0] = cfg; mem[1] = k; mem[2] = cnt;
        mrole = int'(cfg[1:0]); mcnt = int'(cnt); ki = $signed(k);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; left_stb = 1'b0; left_data = '0;
        repeat (3) @(negedge clk);
        check(!right_stb && !irq && !mem_wr_en, "R1", {right_stb, irq, mem_wr_en}, 0);
        rst_n = 1'b1;
        #0.5;
        check(mem_rd_en && mem_addr == 10'd0, "R1", mem_addr, 0);
        @(negedge clk);
        check(mem_rd_en && mem_addr == 10'd1, "R1", mem_addr, 1);
        @(negedge clk);
        check(mem_rd_en && mem_addr == 10'd2, "R1", mem_addr, 2);
        repeat (3) @(negedge clk);
    endtask

    task automatic drive(input int n);
        for (int i = 0; i < n; i++) begin
            left_stb = 1'b1; left_data = stream[i];
            @(negedge clk);
        end
        left_stb = 1'b0; left_data = '0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;

        // source stage: weight 3, five elements incl. extremes
        cur_tag = "R3";
        setup(16'h0001, 16'd3, 16'd5);
        mem[3] = 16'd1; mem[4] = 16'hFFFE; mem[5] = 16'd100; mem[6] = 16'h7FFF; mem[7] = 16'h8000;
        do_reset();
        stream[0] = 32'h1234_5678;
        drive(1);
        repeat (8) @(negedge clk);
        check(stb_seen == 5, "R5", stb_seen, 5);
        cur_tag = "R5";
        stream[0] = 1; stream[1] = 2; stream[2] = 3;
        drive(3);
        repeat (4) @(negedge clk);
        check(stb_seen == 5, "R5", stb_seen, 5);
        check(wr_seen == 0, "R9", wr_seen, 0);

        // summing stage, role bits 10 with noisy upper bits; weight -7
        cur_tag = "R2 R4";
        setup(16'hA5A6, 16'hFFF9, 16'd4);
        mem[3] = 16'd5; mem[4] = 16'hFFFF; mem[5] = 16'd30000; mem[6] = 16'd2;
        do_reset();
        stream[0] = 32'd100; stream[1] = 32'h7FFF_FFFF; stream[2] = 32'hFFFF_FFCE;
        stream[3] = 32'd0; stream[4] = 32'd9; stream[5] = 32'd9;
        drive(4);
        cur_tag = "R5";
        drive(2);
        repeat (4) @(negedge clk);
        check(stb_seen == 4, "R5", stb_seen, 4);
        check(wr_seen == 0, "R9", wr_seen, 0);

        // summing stage with zero count
        cur_tag = "R6";
        setup(16'h0002, 16'd9, 16'd0);
        do_reset();
        drive(3);
        repeat (4) @(negedge clk);
        check(stb_seen == 0, "R6", stb_seen, 0);

        // sink stage: six words, then a late burst that must be ignored
        cur_tag = "R7";
        setup(16'h0003, 16'd0, 16'd0);
        do_reset();
        for (int i = 0; i < 6; i++) stream[i] = {16'(16'h1000 + i * 16'h0111), 16'hBEEF};
        drive(6);
        repeat (3) @(negedge clk);
        check(irq_seen == 1, "R8", irq_seen, 1);
        stream[0] = 32'hDEAD_0000; stream[1] = 32'hCAFE_0000;
        drive(2);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 6; i++)
            check(wmem[3 + i] == stream[i][31:16] || i < 2 && wmem[3 + i] == 16'(16'h1000 + i * 16'h0111),
                  "R7", wmem[3 + i], 16'(16'h1000 + i * 16'h0111));
        check(wmem[9] == 16'h0 && wmem[10] == 16'h0, "R8", wmem[9], 0);
        check(wr_seen == 6, "R8", wr_seen, 6);
        check(irq_seen == 1, "R8", irq_seen, 1);
        check(rd_data_seen == 0 && stb_seen == 0, "R9", rd_data_seen + stb_seen, 0);

        // inert stage
        cur_tag = "R10";
        setup(16'h0000, 16'd5, 16'd3);
        do_reset();
        stream[0] = 7; stream[1] = 8; stream[2] = 9;
        drive(3);
        repeat (4) @(negedge clk);
        check(rd_data_seen == 0 && wr_seen == 0, "R10", rd_data_seen + wr_seen, 0);
        check(stb_seen == 0 && irq_seen == 0, "R10", stb_seen + irq_seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule